// File: doc/BRIEF.md
# Register Floating-Point Tag Tracker

This front-end block keeps one type bit for each architectural register. A set bit means the register currently holds a floating-point value. A clear bit means it holds an integer, an address or some other non-FP value. Decoded instructions arrive one at a time on a valid/ready stream. Loads and arithmetic writes update the tag of their destination register. For an opcode that both units share, the tag of the source register decides which execution unit the operation goes to. The block only uses the decoded fields, so it sits between the decoder and the renamer and needs no execution results.

Procedure entry and exit carry a 32-bit register mask. On entry, the tags of the masked registers are packed into a single word and offered on an outgoing valid/ready stream, so they can be stored in the save area next to the registers. On exit, the block waits for that word to come back from memory on an incoming valid/ready stream. Until it arrives, the block holds a stall and refuses further instructions. It then restores only the masked tag positions.

The rules for back-pressure are as follows. An instruction transfers on a cycle where `dec_valid` and `dec_ready` are both high. An entry instruction is held until `save_ready` is high, because it is not accepted before its tag word is taken. The restore word transfers on a cycle where `rest_valid` and `rest_ready` are both high. `rest_ready` is high only while the block waits on an exit.

Top module: `regtag_tracker`

## Requirements
- R1: After reset every tag is clear, so an entry with an all-ones mask offers a save word of 0.
- R2: The class code is `dec_class`. An accepted FP load (class 2, either width) sets the tag of its destination register `dec_dst`.
- R3: An accepted non-FP load (class 1) clears the tag of its destination register.
- R4: While `dec_valid` is high, `sel_fp` reflects the unit choice. For a shared op (class 3), `sel_fp` equals the tag of `dec_src`. For an FP-only op (class 4), `sel_fp` is 1. For every other class, `sel_fp` is 0.
- R5: An accepted arithmetic instruction (classes 3, 4, 5) sets its destination tag to the value of `sel_fp` for that instruction.
- R6: Entry is class 6. While an entry is presented and no exit is pending, `save_valid` is high. `save_word` bit i then equals tag i where `dec_mask` bit i is set, and 0 elsewhere. The entry is accepted only when `save_ready` is high, and it changes no tag.
- R7: Exit is class 7. Once an exit is accepted, `stall` and `rest_ready` are high and `dec_ready` is low until the restore word transfers. At that transfer, tag i takes `rest_word` bit i where the exit's mask bit i is set. All other tags are unchanged, and `stall` is low on the next cycle.
- R8: An instruction presented in the cycle right after an update sees the updated tags, both in `sel_fp` and in `save_word`.
- R9: A no-op (class 0) or a cycle without an accepted instruction changes no tag. An instruction that is presented while the block is stalled is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_ready | output | 1 | Block accepts the instruction |
| dec_class | input | 3 | Instruction class code |
| dec_dst | input | 5 | Destination register index |
| dec_src | input | 5 | Source register index for steering |
| dec_mask | input | 32 | Register mask for entry and exit |
| sel_fp | output | 1 | 1 selects the FP unit, 0 selects the integer unit |
| save_valid | output | 1 | Tag word offered for the save area |
| save_ready | input | 1 | Save area takes the tag word |
| save_word | output | 32 | Masked tag word |
| stall | output | 1 | Waiting for the restore word |
| rest_valid | input | 1 | Restore word from memory present |
| rest_ready | output | 1 | Block takes the restore word |
| rest_word | input | 32 | Restored tag word |

## Verification
The assertions assume that `dec_class`, `dec_dst` and `dec_mask` are stable and known whenever `dec_valid` is high at a clock edge. They also assume that the memory side raises `rest_valid` only in answer to an exit. The bench changes inputs only on falling edges. It keeps `rest_valid` low except during the single cycle in which it returns the word for an exit. While the block is stalled, it presents an instruction only to show that the instruction is refused.

// File: rtl/regtag_pkg.sv
package regtag_pkg;
  typedef enum logic [2:0] {
    CLS_NOP    = 3'd0,
    CLS_LD_INT = 3'd1,
    CLS_LD_FP  = 3'd2,
    CLS_OP_SHR = 3'd3,
    CLS_OP_FP  = 3'd4,
    CLS_OP_INT = 3'd5,
    CLS_ENTER  = 3'd6,
    CLS_EXIT   = 3'd7
  } cls_e;
endpackage

// File: rtl/regtag_store.sv
module regtag_store #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NREG-1:0] wr_mask,
  input  logic [NREG-1:0] wr_data,
  output logic [NREG-1:0] eff_tags
);
  logic [NREG-1:0] tags_q;
  logic            wb_vld_q;
  logic [NREG-1:0] wb_mask_q;
  logic [NREG-1:0] wb_data_q;
  logic [NREG-1:0] merged;

  assign merged   = (tags_q & ~wb_mask_q) | (wb_data_q & wb_mask_q);
  assign eff_tags = wb_vld_q ? merged : tags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tags_q    <= '0;
      wb_vld_q  <= 1'b0;
      wb_mask_q <= '0;
      wb_data_q <= '0;
    end else begin
      if (wb_vld_q) tags_q <= merged;
      wb_vld_q <= wr_en;
      if (wr_en) begin
        wb_mask_q <= wr_mask;
        wb_data_q <= wr_data;
      end
    end
  end

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_vld_q |=> tags_q == $past(tags_q));

  p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld_q |=> ((tags_q ^ $past(wb_data_q)) & $past(wb_mask_q)) == '0);
endmodule

// File: rtl/regtag_steer.sv
module regtag_steer
  import regtag_pkg::*;
#(
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  cls_e            cls,
  input  logic [IW-1:0]   dst,
  input  logic [IW-1:0]   src,
  input  logic [NREG-1:0] eff_tags,
  output logic            sel_fp,
  output logic            upd_en,
  output logic [NREG-1:0] upd_mask,
  output logic [NREG-1:0] upd_data
);
  logic dst_val;

  always_comb begin
    case (cls)
      CLS_OP_SHR: sel_fp = eff_tags[src];
      CLS_OP_FP:  sel_fp = 1'b1;
      default:    sel_fp = 1'b0;
    endcase
  end

  always_comb begin
    upd_en  = 1'b0;
    dst_val = 1'b0;
    case (cls)
      CLS_LD_INT: upd_en = 1'b1;
      CLS_LD_FP:  begin upd_en = 1'b1; dst_val = 1'b1; end
      CLS_OP_SHR, CLS_OP_FP, CLS_OP_INT: begin upd_en = 1'b1; dst_val = sel_fp; end
      default: ;
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    assign upd_mask[i] = (dst == IW'(i));
    assign upd_data[i] = dst_val;
  end
endmodule

// File: rtl/regtag_exitctl.sv
module regtag_exitctl #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NREG-1:0] mask_in,
  input  logic            rest_valid,
  output logic            waiting,
  output logic            rest_fire,
  output logic [NREG-1:0] pend_mask
);
  logic            wait_q;
  logic [NREG-1:0] mask_q;

  assign waiting   = wait_q;
  assign pend_mask = mask_q;
  assign rest_fire = wait_q && rest_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      mask_q <= '0;
    end else if (rest_fire) begin
      wait_q <= 1'b0;
    end else if (start) begin
      wait_q <= 1'b1;
      mask_q <= mask_in;
    end
  end

  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q && !rest_valid |=> wait_q);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rest_fire |=> !wait_q);
endmodule

// File: rtl/regtag_tracker.sv
module regtag_tracker
  import regtag_pkg::*;
#(
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  output logic            dec_ready,
  input  logic [2:0]      dec_class,
  input  logic [IW-1:0]   dec_dst,
  input  logic [IW-1:0]   dec_src,
  input  logic [NREG-1:0] dec_mask,
  output logic            sel_fp,
  output logic            save_valid,
  input  logic            save_ready,
  output logic [NREG-1:0] save_word,
  output logic            stall,
  input  logic            rest_valid,
  output logic            rest_ready,
  input  logic [NREG-1:0] rest_word
);
  cls_e            cls;
  logic [NREG-1:0] eff_tags;
  logic            upd_en;
  logic [NREG-1:0] upd_mask, upd_data;
  logic            waiting, rest_fire, accept;
  logic [NREG-1:0] pend_mask;
  logic            wr_en;
  logic [NREG-1:0] wr_mask, wr_data;

  assign cls        = cls_e'(dec_class);
  assign dec_ready  = !waiting && !(cls == CLS_ENTER && !save_ready);
  assign accept     = dec_valid && dec_ready;
  assign save_valid = dec_valid && !waiting && cls == CLS_ENTER;
  assign save_word  = eff_tags & dec_mask;
  assign stall      = waiting;
  assign rest_ready = waiting;

  assign wr_en   = rest_fire || (accept && upd_en);
  assign wr_mask = rest_fire ? pend_mask : upd_mask;
  assign wr_data = rest_fire ? rest_word : upd_data;

  regtag_store #(.NREG(NREG)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
    .wr_data(wr_data), .eff_tags(eff_tags)
  );

  regtag_steer #(.NREG(NREG), .IW(IW)) u_steer (
    .cls(cls), .dst(dec_dst), .src(dec_src), .eff_tags(eff_tags),
    .sel_fp(sel_fp), .upd_en(upd_en), .upd_mask(upd_mask), .upd_data(upd_data)
  );

  regtag_exitctl #(.NREG(NREG)) u_exit (
    .clk(clk), .rst_n(rst_n), .start(accept && cls == CLS_EXIT),
    .mask_in(dec_mask), .rest_valid(rest_valid), .waiting(waiting),
    .rest_fire(rest_fire), .pend_mask(pend_mask)
  );

  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !dec_ready);

  p_save_backpr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid && !save_ready |-> !dec_ready);

  p_fpload_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cls == CLS_LD_FP |=> eff_tags[$past(dec_dst)]);

  p_intload_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cls == CLS_LD_INT |=> !eff_tags[$past(dec_dst)]);

  p_arith_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cls == CLS_OP_SHR || cls == CLS_OP_FP || cls == CLS_OP_INT)
    |=> eff_tags[$past(dec_dst)] == $past(sel_fp));

  p_unmasked_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rest_fire |=> ((eff_tags ^ $past(eff_tags)) & ~$past(pend_mask)) == '0);
endmodule

// File: tb/test_regtag_tracker.sv
module test_regtag_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic        dec_ready;
  logic [2:0]  dec_class = 3'd0;
  logic [4:0]  dec_dst = 5'd0;
  logic [4:0]  dec_src = 5'd0;
  logic [31:0] dec_mask = 32'd0;
  logic        sel_fp;
  logic        save_valid;
  logic        save_ready = 1'b1;
  logic [31:0] save_word;
  logic        stall;
  logic        rest_valid = 1'b0;
  logic        rest_ready;
  logic [31:0] rest_word = 32'd0;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] model = 32'd0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  regtag_tracker i_regtag_tracker (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_class(dec_class), .dec_dst(dec_dst), .dec_src(dec_src),
    .dec_mask(dec_mask), .sel_fp(sel_fp), .save_valid(save_valid),
    .save_ready(save_ready), .save_word(save_word), .stall(stall),
    .rest_valid(rest_valid), .rest_ready(rest_ready), .rest_word(rest_word)
  );

  // {class, dst, src, expected sel_fp}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {3'd2, 5'd3,  5'd0,  1'b0},  // R2 FP load r3
    {3'd3, 5'd4,  5'd3,  1'b1},  // R8 bypass, R4 shared -> FP
    {3'd3, 5'd5,  5'd4,  1'b1},  // R5 dst tag follows unit
    {3'd1, 5'd3,  5'd0,  1'b0},  // R3 int load clears r3
    {3'd3, 5'd6,  5'd3,  1'b0},  // R3/R4 shared -> int
    {3'd4, 5'd7,  5'd0,  1'b1},  // R4 FP-only op
    {3'd3, 5'd8,  5'd7,  1'b1},  // R5 FP-only result tagged
    {3'd5, 5'd7,  5'd0,  1'b0},  // R4 int-only op
    {3'd3, 5'd9,  5'd7,  1'b0},  // R5 int result untagged
    {3'd0, 5'd5,  5'd5,  1'b0},  // R9 no-op
    {3'd3, 5'd10, 5'd5,  1'b1},  // R9 r5 kept its tag
    {3'd2, 5'd31, 5'd0,  1'b0},  // R2 top register
    {3'd3, 5'd0,  5'd31, 1'b1}   // R8 bypass on r31
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_model(input logic [2:0] c, input logic [4:0] d, input logic s);
    case (c)
      3'd1: model[d] = 1'b0;
      3'd2: model[d] = 1'b1;
      3'd3, 3'd4, 3'd5: model[d] = s;
      default: ;
    endcase
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    check("R1 stall", {31'd0, stall}, 32'd0);
    check("R1 ready", {31'd0, dec_ready}, 32'd1);
    dec_valid = 1'b1; dec_class = 3'd6; dec_mask = 32'hFFFF_FFFF;
    #1;
    check("R1 save_word", save_word, 32'd0);
    dec_valid = 1'b0;
    @(negedge clk);

    // table walk
    for (int k = 0; k < NV; k++) begin
      dec_valid = 1'b1;
      dec_class = VEC[k][13:11];
      dec_dst   = VEC[k][10:6];
      dec_src   = VEC[k][5:1];
      #1;
      check($sformatf("R4 vec%0d sel_fp", k), {31'd0, sel_fp}, {31'd0, VEC[k][0]});
      apply_model(VEC[k][13:11], VEC[k][10:6], VEC[k][0]);
      @(negedge clk);
    end

    // R6 entry full mask reflects all updates, read right after last (R8)
    dec_class = 3'd6; dec_mask = 32'hFFFF_FFFF;
    #1;
    check("R6 save full", save_word, model);
    check("R6 save_valid", {31'd0, save_valid}, 32'd1);
    // R6 back-pressure
    save_ready = 1'b0;
    #1;
    check("R6 backpressure ready", {31'd0, dec_ready}, 32'd0);
    check("R6 backpressure valid", {31'd0, save_valid}, 32'd1);
    save_ready = 1'b1;
    dec_mask = 32'h0000_0F30;
    #1;
    check("R6 save partial", save_word, model & 32'h0000_0F30);
    check("R6 ready", {31'd0, dec_ready}, 32'd1);
    @(negedge clk);

    // R7 exit
    dec_class = 3'd7; dec_mask = 32'h0000_00F0;
    @(negedge clk);
    dec_class = 3'd2; dec_dst = 5'd1; // presented while stalled, R9
    for (int w = 0; w < 3; w++) begin
      #1;
      check("R7 stall", {29'd0, stall, rest_ready, dec_ready}, {29'd0, 3'b110});
      @(negedge clk);
    end
    dec_valid = 1'b0;
    rest_valid = 1'b1; rest_word = 32'hFFFF_FF0F;
    model = (model & ~32'h0000_00F0) | (32'hFFFF_FF0F & 32'h0000_00F0);
    @(negedge clk);
    rest_valid = 1'b0; rest_word = 32'd0;
    #1;
    check("R7 stall drops", {31'd0, stall}, 32'd0);
    dec_valid = 1'b1; dec_class = 3'd6; dec_mask = 32'hFFFF_FFFF;
    #1;
    check("R7 restore masked, R9 stalled load ignored, R8 bypass", save_word, model);
    dec_valid = 1'b0;
    @(negedge clk);

    // R7 restore that sets masked bits
    dec_valid = 1'b1; dec_class = 3'd7; dec_mask = 32'h8000_0006;
    @(negedge clk);
    dec_valid = 1'b0;
    rest_valid = 1'b1; rest_word = 32'h8000_0004;
    model = (model & ~32'h8000_0006) | 32'h8000_0004;
    @(negedge clk);
    rest_valid = 1'b0;
    dec_valid = 1'b1; dec_class = 3'd3; dec_src = 5'd2; dec_dst = 5'd12;
    #1;
    check("R7 restored r2 steers FP", {31'd0, sel_fp}, 32'd1);
    model[12] = 1'b1;
    @(negedge clk);
    dec_class = 3'd6; dec_mask = 32'hFFFF_FFFF;
    #1;
    check("R7 second restore", save_word, model);
    dec_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule